// File: doc/BRIEF.md
# Relocatable Power-Management and SMBus I/O Window Decoder

This block holds the configuration registers of a power-management PCI function that places two I/O windows in the 16-bit I/O space: a 128-byte window for power-management registers and a 16-byte window for an SMBus controller. Software moves each window by writing a base register through a byte-enabled, dword-addressed configuration port. It turns each window on with an enable bit that sits in a separate control dword. The block forces the read-only low bits of each base register as it stores the value, so a read returns exactly what the decoder uses.

On the I/O side the block compares every cycle's I/O address against both windows. For each window it reports a hit and the byte offset inside that window, so the registers behind the window can be selected. A hit is combinational. A configuration read returns its data one clock after the request.

Top module: `pmio_window_dec`

## Requirements
- R1: After reset, dword index 0x12 (PM base) and 0x24 (SMBus base) read 0x00000001, dword indices 0x10 and 0x34 read 0x00000000, and neither hit output is asserted.
- R2: A write to dword 0x12 merges the enabled bytes into the stored value, then stores (merged AND 0x0000FF80) OR 0x00000001; a write with no byte enable leaves it unchanged.
- R3: A write to dword 0x24 merges the enabled bytes, then stores (merged AND 0x0000FFF0) OR 0x00000001.
- R4: In dword 0x34, bits 23:20 always read zero and bits 19:16 keep what is written; its other bytes, and all four bytes of dword 0x10, store the written byte as is.
- R5: pm_hit is 1 when bit 15 of dword 0x10 is set and io_addr[15:7] equals PM base bits 15:7; pm_ofs always equals io_addr[6:0].
- R6: smb_hit is 1 when bit 16 of dword 0x34 is set and io_addr[15:4] equals SMBus base bits 15:4; smb_ofs always equals io_addr[3:0].
- R7: cfg_rdata shows the addressed register on the clock after cfg_rd is sampled high and holds its value on every clock where cfg_rd is low.
- R8: Any other dword index reads 0x00000000, and a write to it changes none of the four registers.
- R9: With its enable bit clear, a window's hit stays 0 even when io_addr lies inside its base range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset bits 7:2) |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| io_addr | input | 16 | I/O cycle address |
| pm_hit | output | 1 | Address falls in the enabled PM window |
| pm_ofs | output | 7 | Offset inside the PM window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |
| smb_ofs | output | 4 | Offset inside the SMBus window |

## Verification
On every cycle the checker confirms that a read of either base register returns the forced low bits and clear upper half, that the reserved high nibble of the SMBus control byte reads zero, that unmapped dwords read zero and that read data holds between reads. Partial-byte merging, the exact window boundaries, the effect of clearing each enable bit, and recovery of reset values after a second reset need known stimulus and expected values, so only the bench's scenarios show them.

// File: rtl/pmio_pkg.sv
package pmio_pkg;
  localparam int CFG_DW_W = 6;
  localparam int REG_N    = 4;

  // Register slots, index order used across the block.
  localparam int SLOT_PMCTL  = 0;
  localparam int SLOT_PMBASE = 1;
  localparam int SLOT_SMBASE = 2;
  localparam int SLOT_SMCTL  = 3;

  localparam logic [REG_N-1:0][CFG_DW_W-1:0] SLOT_DW = {
    6'h34,  // SMBus control dword (byte 0xD2 holds the enable)
    6'h24,  // SMBus base
    6'h12,  // PM base
    6'h10   // PM control dword (byte 0x41 holds the enable)
  };

  localparam int PM_EN_BIT  = 15;
  localparam int SMB_EN_BIT = 16;
endpackage

// File: rtl/pmio_cfg_reg.sv
module pmio_cfg_reg #(
  parameter logic [31:0] KEEP  = 32'hFFFF_FFFF,
  parameter logic [31:0] FORCE = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] merged;
  logic [31:0] q_nxt;

  for (genvar b = 0; b < 4; b++) begin : g_byte
    always_comb begin
      merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : q[b*8 +: 8];
    end
  end

  always_comb begin
    q_nxt = (merged & KEEP) | FORCE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= FORCE;
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/pmio_win_cmp.sv
module pmio_win_cmp #(
  parameter int AW        = 16,
  parameter int SIZE_LOG2 = 7
) (
  input  logic                 en,
  input  logic [AW-1:SIZE_LOG2] base_hi,
  input  logic [AW-1:0]        io_addr,
  output logic                 hit,
  output logic [SIZE_LOG2-1:0] ofs
);
  always_comb begin
    hit = en && (io_addr[AW-1:SIZE_LOG2] == base_hi);
    ofs = io_addr[SIZE_LOG2-1:0];
  end
endmodule

// File: rtl/pmio_rd_port.sv
module pmio_rd_port
  import pmio_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [CFG_DW_W-1:0]          dw,
  input  logic [REG_N-1:0][31:0]       regs,
  output logic [31:0]                  rdata
);
  logic [31:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < REG_N; i++) begin
      if (dw == SLOT_DW[i]) sel = sel | regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= sel;
    end
  end
endmodule

// File: rtl/pmio_window_dec.sv
module pmio_window_dec
  import pmio_pkg::*;
#(
  parameter int IO_AW      = 16,
  parameter int PM_SZ_LOG2 = 7,
  parameter int SMB_SZ_LOG2 = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic                   cfg_rd,
  input  logic [CFG_DW_W-1:0]    cfg_dw,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [IO_AW-1:0]       io_addr,
  output logic                   pm_hit,
  output logic [PM_SZ_LOG2-1:0]  pm_ofs,
  output logic                   smb_hit,
  output logic [SMB_SZ_LOG2-1:0] smb_ofs
);
  localparam logic [31:0] AW_MASK  = 32'((64'd1 << IO_AW) - 64'd1);
  localparam logic [31:0] PM_KEEP  = AW_MASK & ~32'((64'd1 << PM_SZ_LOG2) - 64'd1);
  localparam logic [31:0] SMB_KEEP = AW_MASK & ~32'((64'd1 << SMB_SZ_LOG2) - 64'd1);
  localparam logic [31:0] SMCTL_KEEP = 32'hFF0F_FFFF;

  localparam logic [REG_N-1:0][31:0] KEEP  = {SMCTL_KEEP, SMB_KEEP, PM_KEEP, 32'hFFFF_FFFF};
  localparam logic [REG_N-1:0][31:0] FORCE = {32'h0, 32'h1, 32'h1, 32'h0};

  logic [REG_N-1:0][31:0] regs;
  logic [REG_N-1:0]       wr_sel;

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    always_comb begin
      wr_sel[i] = cfg_wr && (cfg_dw == SLOT_DW[i]) && (cfg_be != 4'b0000);
    end
    pmio_cfg_reg #(
      .KEEP (KEEP[i]),
      .FORCE(FORCE[i])
    ) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_sel[i]),
      .be   (cfg_be),
      .wdata(cfg_wdata),
      .q    (regs[i])
    );
  end

  pmio_rd_port u_rd (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(cfg_rd),
    .dw   (cfg_dw),
    .regs (regs),
    .rdata(cfg_rdata)
  );

  pmio_win_cmp #(.AW(IO_AW), .SIZE_LOG2(PM_SZ_LOG2)) u_pm (
    .en     (regs[SLOT_PMCTL][PM_EN_BIT]),
    .base_hi(regs[SLOT_PMBASE][IO_AW-1:PM_SZ_LOG2]),
    .io_addr(io_addr),
    .hit    (pm_hit),
    .ofs    (pm_ofs)
  );

  pmio_win_cmp #(.AW(IO_AW), .SIZE_LOG2(SMB_SZ_LOG2)) u_smb (
    .en     (regs[SLOT_SMCTL][SMB_EN_BIT]),
    .base_hi(regs[SLOT_SMBASE][IO_AW-1:SMB_SZ_LOG2]),
    .io_addr(io_addr),
    .hit    (smb_hit),
    .ofs    (smb_ofs)
  );
endmodule

// File: rtl/pmio_window_dec_chk.sv
module pmio_window_dec_chk
  import pmio_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_rd,
  input logic [CFG_DW_W-1:0] cfg_dw,
  input logic [31:0]         cfg_rdata
);
  logic known_dw;
  always_comb begin
    known_dw = (cfg_dw == SLOT_DW[0]) || (cfg_dw == SLOT_DW[1]) ||
               (cfg_dw == SLOT_DW[2]) || (cfg_dw == SLOT_DW[3]);
  end

  a_r2_pm_base_form: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_dw == SLOT_DW[SLOT_PMBASE]) |=>
      (cfg_rdata[6:0] == 7'h01 && cfg_rdata[31:16] == 16'h0));

  a_r3_smb_base_form: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_dw == SLOT_DW[SLOT_SMBASE]) |=>
      (cfg_rdata[3:0] == 4'h1 && cfg_rdata[31:16] == 16'h0));

  a_r4_smctl_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_dw == SLOT_DW[SLOT_SMCTL]) |=> (cfg_rdata[23:20] == 4'h0));

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !known_dw) |=> (cfg_rdata == 32'h0));
endmodule

bind pmio_window_dec pmio_window_dec_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_rd   (cfg_rd),
  .cfg_dw   (cfg_dw),
  .cfg_rdata(cfg_rdata)
);

// File: tb/pmio_window_dec_test.sv
module pmio_window_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        pm_hit;
  logic [6:0]  pm_ofs;
  logic        smb_hit;
  logic [3:0]  smb_ofs;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pmio_window_dec uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_addr(io_addr), .pm_hit(pm_hit),
    .pm_ofs(pm_ofs), .smb_hit(smb_hit), .smb_ofs(smb_ofs)
  );

  // op: 0 write, 1 read (exp = rdata), 2 io probe
  // io exp packing: bit13 pm_hit, bit12 smb_hit, bits10:4 pm_ofs, bits3:0 smb_ofs
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'd1, 6'h12, 4'h0, 32'h0,         32'h0000_0001}, // R1
    '{2'd1, 4'd1, 6'h24, 4'h0, 32'h0,         32'h0000_0001}, // R1
    '{2'd1, 4'd1, 6'h10, 4'h0, 32'h0,         32'h0000_0000}, // R1
    '{2'd1, 4'd1, 6'h34, 4'h0, 32'h0,         32'h0000_0000}, // R1
    '{2'd2, 4'd1, 6'h00, 4'h0, 32'h0000_0000, 32'h0000_0000}, // R1
    '{2'd0, 4'd2, 6'h12, 4'hF, 32'hABCD_1234, 32'h0},
    '{2'd1, 4'd2, 6'h12, 4'h0, 32'h0,         32'h0000_1201}, // R2
    '{2'd0, 4'd2, 6'h12, 4'h1, 32'h0000_00FF, 32'h0},
    '{2'd1, 4'd2, 6'h12, 4'h0, 32'h0,         32'h0000_1281}, // R2 partial
    '{2'd0, 4'd2, 6'h12, 4'h0, 32'hFFFF_FFFF, 32'h0},
    '{2'd1, 4'd2, 6'h12, 4'h0, 32'h0,         32'h0000_1281}, // R2 no enables
    '{2'd0, 4'd5, 6'h10, 4'h2, 32'h0000_8000, 32'h0},
    '{2'd1, 4'd4, 6'h10, 4'h0, 32'h0,         32'h0000_8000}, // R4
    '{2'd2, 4'd5, 6'h00, 4'h0, 32'h0000_1285, 32'h0000_2055}, // R5
    '{2'd2, 4'd5, 6'h00, 4'h0, 32'h0000_1300, 32'h0000_0000}, // R5 above
    '{2'd2, 4'd5, 6'h00, 4'h0, 32'h0000_12FF, 32'h0000_27FF}, // R5 top
    '{2'd0, 4'd3, 6'h24, 4'hF, 32'hFFFF_C3A7, 32'h0},
    '{2'd1, 4'd3, 6'h24, 4'h0, 32'h0,         32'h0000_C3A1}, // R3
    '{2'd0, 4'd4, 6'h34, 4'h4, 32'h00FF_0000, 32'h0},
    '{2'd1, 4'd4, 6'h34, 4'h0, 32'h0,         32'h000F_0000}, // R4
    '{2'd2, 4'd6, 6'h00, 4'h0, 32'h0000_C3A9, 32'h0000_1299}, // R6
    '{2'd2, 4'd6, 6'h00, 4'h0, 32'h0000_C3B0, 32'h0000_0300}, // R6 above
    '{2'd0, 4'd4, 6'h34, 4'hB, 32'hAA55_3311, 32'h0},
    '{2'd1, 4'd4, 6'h34, 4'h0, 32'h0,         32'hAA0F_3311}, // R4
    '{2'd0, 4'd8, 6'h11, 4'hF, 32'hFFFF_FFFF, 32'h0},
    '{2'd1, 4'd8, 6'h11, 4'h0, 32'h0,         32'h0000_0000}, // R8
    '{2'd1, 4'd8, 6'h12, 4'h0, 32'h0,         32'h0000_1281}, // R8
    '{2'd0, 4'd9, 6'h10, 4'h2, 32'h0000_0000, 32'h0},
    '{2'd2, 4'd9, 6'h00, 4'h0, 32'h0000_1285, 32'h0000_0055}, // R9 pm off
    '{2'd0, 4'd9, 6'h34, 4'h4, 32'h00FE_0000, 32'h0}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic do_rd(input logic [5:0] dw, output logic [31:0] v);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw = dw;
    @(negedge clk);
    cfg_rd = 1'b0;
    v = cfg_rdata;
  endtask

  task automatic do_io(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    io_addr = a;
    #1;
    v = {18'b0, pm_hit, smb_hit, 1'b0, pm_ofs, smb_ofs};
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: do_wr(VEC[i].dw, VEC[i].be, VEC[i].d);
        2'd1: begin
          do_rd(VEC[i].dw, v);
          check(int'(VEC[i].req), $sformatf("vector %0d read", i), v, VEC[i].exp);
        end
        default: begin
          do_io(VEC[i].d[15:0], v);
          check(int'(VEC[i].req), $sformatf("vector %0d io", i), v, VEC[i].exp);
        end
      endcase
    end

    // R9: SMBus enable cleared (byte 0xD2 now 0x0E), address still in window
    do_rd(6'h34, v);
    check(9, "smctl after enable clear", v, 32'hAA0E_3311);
    do_io(16'hC3A9, v);
    check(9, "smb off inside window", v, 32'h0000_0299);

    // R5/R6 both windows re-enabled, boundary just below PM window
    do_wr(6'h10, 4'h2, 32'h0000_8000);
    do_wr(6'h34, 4'h4, 32'h0001_0000);
    do_io(16'h127F, v);
    check(5, "below pm window", v, 32'h0000_07FF);
    do_io(16'h1280, v);
    check(5, "pm window base", v, 32'h0000_2000);
    do_io(16'hC3AF, v);
    check(6, "smb window top", v, 32'h0000_12FF);

    // R7: latency one clock, value held across idle clocks
    do_rd(6'h12, v);
    check(7, "read pm base", v, 32'h0000_1281);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw = 6'h24;
    #1;
    check(7, "rdata before edge", cfg_rdata, 32'h0000_1281);
    @(negedge clk);
    cfg_rd = 1'b0; cfg_dw = 6'h10;
    check(7, "rdata after edge", cfg_rdata, 32'h0000_C3A1);
    repeat (3) @(negedge clk);
    check(7, "rdata held", cfg_rdata, 32'h0000_C3A1);

    // R1: second reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_rd(6'h12, v);
    check(1, "pm base after reset", v, 32'h0000_0001);
    do_rd(6'h34, v);
    check(1, "smctl after reset", v, 32'h0000_0000);
    do_io(16'h0001, v);
    check(1, "no hit after reset", v, 32'h0000_0011);

    finish_run();
  end
endmodule